// File: doc/BRIEF.md
# Pipeline Issue Stall and Memory Port Arbitration Controller

This controller governs instruction issue in a five-stage in-order pipeline: fetch, decode with register read, execute, memory access, writeback. It keeps a short record of the instructions that have left decode. For each one it holds a valid bit, the destination register index, a register-write flag and a flag marking it as a load or store. Each cycle it compares the decode-stage source fields against that record. From the comparison it decides whether decode must hold, whether a no-op bubble must be pushed into execute, whether fetch may drive the memory port, and whether either source operand must take the value being written back in the same cycle.

Operands pass forward only from writeback to decode. A consumer therefore stays held while its producer sits in execute or memory, and it proceeds in the producer's writeback cycle with the bypass select raised. When the memory mode input selects one shared port for instructions and data, fetch is blocked in any cycle where a load or store occupies the memory stage. When the input selects separate instruction and data memories, data accesses never block fetch. A parameter can remove the shared-port arbitration logic for builds that only ever use separate memories.

Top module: `pipe_issue_ctl`

## Requirements
- R1: After reset, and while reset is held, the record of in-flight instructions is empty. `dec_stall`, `bubble_ins`, `byp_src1` and `byp_src2` are 0 and `fetch_en` is 1, whatever the decode inputs are.
- R2: `dec_stall` is 1 when a valid decode instruction reads a used source register that the execute-stage instruction writes.
- R3: `dec_stall` is 1 when a valid decode instruction reads a used source register that the memory-stage instruction writes.
- R4: A data stall ends in the cycle the producer reaches writeback. A consumer of a load decoded right behind it is held for exactly two cycles.
- R5: Register index 0 never causes a stall or a bypass. A producer whose register-write flag is 0 never causes a stall or a bypass.
- R6: `byp_src1` (or `byp_src2`) is 1 exactly when a valid decode instruction uses source 1 (or source 2) with a nonzero index equal to the writeback-stage destination and writeback writes a register. The two selects are independent.
- R7: With `split_mem` = 0 (one shared port), `fetch_en` is 0 in any cycle where the memory-stage instruction is a load or store.
- R8: With `split_mem` = 1 (separate memories), a load or store in the memory stage never drives `fetch_en` low.
- R9: During a data stall `bubble_ins` is 1 and `fetch_en` is 0. The held instruction does not enter execute; a bubble enters instead, and that bubble neither writes a register nor uses the memory port.
- R10: A source field whose use flag is 0 never causes a stall or a bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_mem | input | 1 | 0 = one shared memory port, 1 = separate instruction and data memories |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_src1_use | input | 1 | Source 1 is read by the decode instruction |
| dec_src1 | input | REG_W | Source 1 register index |
| dec_src2_use | input | 1 | Source 2 is read by the decode instruction |
| dec_src2 | input | REG_W | Source 2 register index |
| dec_dst | input | REG_W | Destination register index |
| dec_wr | input | 1 | Decode instruction writes a register |
| dec_load | input | 1 | Decode instruction is a load |
| dec_store | input | 1 | Decode instruction is a store |
| fetch_en | output | 1 | Fetch may use the memory port and advance the PC |
| dec_stall | output | 1 | Hold the PC and the fetch/decode register |
| bubble_ins | output | 1 | Load a no-op into execute |
| byp_src1 | output | 1 | Source 1 takes the writeback value |
| byp_src2 | output | 1 | Source 2 takes the writeback value |

## Verification
A destination, write flag or memory flag that is wrong in the in-flight record shows up at the ports within one to three cycles. A missed or extra stall appears while the entry sits in execute or memory. A missing or spurious bypass select appears in the writeback cycle. A `fetch_en` that is low in the wrong cycle, or not low when it should be, appears while the entry is in memory. If a held instruction leaks into execute, the ports show a stall that lasts one cycle too long, or a port block that is extra or late. For that reason the stimulus holds stalled instructions and places stores and loads behind stalls.

// File: rtl/pipe_issue_pkg.sv
package pipe_issue_pkg;
   localparam int STG_EX   = 0;
   localparam int STG_MEM  = 1;
   localparam int STG_WB   = 2;
   localparam int NUM_TRK  = 3;
   localparam int NUM_SRC  = 2;

   typedef enum logic {
      MEM_SHARED = 1'b0,
      MEM_SPLIT  = 1'b1
   } mem_mode_e;
endpackage

// File: rtl/pipe_issue_track.sv
module pipe_issue_track
   import pipe_issue_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_v,
   input  logic [REG_W-1:0] ins_dst,
   input  logic             ins_wr,
   input  logic             ins_mop,
   input  logic             bubble,
   output logic             st_v   [NUM_TRK],
   output logic [REG_W-1:0] st_dst [NUM_TRK],
   output logic             st_wr  [NUM_TRK],
   output logic             st_mop [NUM_TRK]
);
   // entry point: execute stage, filled from decode or with a bubble
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_v[STG_EX]   <= 1'b0;
         st_dst[STG_EX] <= '0;
         st_wr[STG_EX]  <= 1'b0;
         st_mop[STG_EX] <= 1'b0;
      end else if (bubble || !ins_v) begin
         st_v[STG_EX]   <= 1'b0;
         st_dst[STG_EX] <= '0;
         st_wr[STG_EX]  <= 1'b0;
         st_mop[STG_EX] <= 1'b0;
      end else begin
         st_v[STG_EX]   <= 1'b1;
         st_dst[STG_EX] <= ins_dst;
         st_wr[STG_EX]  <= ins_wr;
         st_mop[STG_EX] <= ins_mop;
      end
   end

   // later stages advance unconditionally
   for (genvar g = 1; g < NUM_TRK; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_v[g]   <= 1'b0;
            st_dst[g] <= '0;
            st_wr[g]  <= 1'b0;
            st_mop[g] <= 1'b0;
         end else begin
            st_v[g]   <= st_v[g-1];
            st_dst[g] <= st_dst[g-1];
            st_wr[g]  <= st_wr[g-1];
            st_mop[g] <= st_mop[g-1];
         end
      end
   end

   // R9: a cycle with bubble set leaves execute empty of writes and memory ops
   p_bubble_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bubble |=> (!st_wr[STG_EX] && !st_mop[STG_EX]));
endmodule

// File: rtl/pipe_issue_hazard.sv
module pipe_issue_hazard
   import pipe_issue_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_valid,
   input  logic             src_use [NUM_SRC],
   input  logic [REG_W-1:0] src_idx [NUM_SRC],
   input  logic             st_v    [NUM_TRK],
   input  logic [REG_W-1:0] st_dst  [NUM_TRK],
   input  logic             st_wr   [NUM_TRK],
   output logic             stall,
   output logic [NUM_SRC-1:0] byp
);
   logic [NUM_SRC-1:0] src_hit;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic live;
      logic hit_ex, hit_mem, hit_wb;
      assign live    = dec_valid && src_use[s] && (src_idx[s] != '0);
      assign hit_ex  = st_v[STG_EX]  && st_wr[STG_EX]  && (st_dst[STG_EX]  == src_idx[s]);
      assign hit_mem = st_v[STG_MEM] && st_wr[STG_MEM] && (st_dst[STG_MEM] == src_idx[s]);
      assign hit_wb  = st_v[STG_WB]  && st_wr[STG_WB]  && (st_dst[STG_WB]  == src_idx[s]);
      assign src_hit[s] = live && (hit_ex || hit_mem);
      assign byp[s]     = live && hit_wb;
   end

   assign stall = |src_hit;

   // R5: no stall is ever driven by a register-zero source
   p_zero_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> ((src_use[0] && src_idx[0] != '0) || (src_use[1] && src_idx[1] != '0)));
   // R4: a held instruction with unchanged fields waits at most two cycles
   p_stall_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && $past(stall) && $stable(src_idx[0]) && $stable(src_idx[1])) |=> !stall);
   // R6: a bypass select needs a writing instruction in writeback
   p_byp_needs_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|byp) |-> (st_v[STG_WB] && st_wr[STG_WB]));
endmodule

// File: rtl/pipe_issue_arb.sv
module pipe_issue_arb
   import pipe_issue_pkg::*;
#(
   parameter bit SHARED_CAPABLE = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  mem_mode_e mode,
   input  logic      mem_v,
   input  logic      mem_mop,
   input  logic      stall,
   output logic      fetch_en
);
   logic port_busy;

   if (SHARED_CAPABLE) begin : g_shared
      assign port_busy = (mode == MEM_SHARED) && mem_v && mem_mop;
   end else begin : g_split_only
      assign port_busy = 1'b0;
   end

   assign fetch_en = !stall && !port_busy;

   // R8: separate memories never block fetch for data
   p_split_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MEM_SPLIT && !stall) |-> fetch_en);
   // R9: a data stall also holds fetch
   p_stall_holds_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !fetch_en);
endmodule

// File: rtl/pipe_issue_ctl.sv
module pipe_issue_ctl
   import pipe_issue_pkg::*;
#(
   parameter int REG_W          = 5,
   parameter bit SHARED_CAPABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             split_mem,
   input  logic             dec_valid,
   input  logic             dec_src1_use,
   input  logic [REG_W-1:0] dec_src1,
   input  logic             dec_src2_use,
   input  logic [REG_W-1:0] dec_src2,
   input  logic [REG_W-1:0] dec_dst,
   input  logic             dec_wr,
   input  logic             dec_load,
   input  logic             dec_store,
   output logic             fetch_en,
   output logic             dec_stall,
   output logic             bubble_ins,
   output logic             byp_src1,
   output logic             byp_src2
);
   if (REG_W < 1 || REG_W > 8) begin : g_bad_width
      $error("pipe_issue_ctl: REG_W must be within 1..8");
   end

   logic             st_v   [NUM_TRK];
   logic [REG_W-1:0] st_dst [NUM_TRK];
   logic             st_wr  [NUM_TRK];
   logic             st_mop [NUM_TRK];
   logic             src_use [NUM_SRC];
   logic [REG_W-1:0] src_idx [NUM_SRC];
   logic [NUM_SRC-1:0] byp;
   logic             stall;
   mem_mode_e        mode;

   assign mode       = split_mem ? MEM_SPLIT : MEM_SHARED;
   assign src_use[0] = dec_src1_use;
   assign src_use[1] = dec_src2_use;
   assign src_idx[0] = dec_src1;
   assign src_idx[1] = dec_src2;

   pipe_issue_track #(.REG_W(REG_W)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .ins_v   (dec_valid),
      .ins_dst (dec_dst),
      .ins_wr  (dec_wr),
      .ins_mop (dec_load || dec_store),
      .bubble  (stall),
      .st_v    (st_v),
      .st_dst  (st_dst),
      .st_wr   (st_wr),
      .st_mop  (st_mop)
   );

   pipe_issue_hazard #(.REG_W(REG_W)) u_hazard (
      .clk       (clk),
      .rst_n     (rst_n),
      .dec_valid (dec_valid),
      .src_use   (src_use),
      .src_idx   (src_idx),
      .st_v      (st_v),
      .st_dst    (st_dst),
      .st_wr     (st_wr),
      .stall     (stall),
      .byp       (byp)
   );

   pipe_issue_arb #(.SHARED_CAPABLE(SHARED_CAPABLE)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .mem_v    (st_v[STG_MEM]),
      .mem_mop  (st_mop[STG_MEM]),
      .stall    (stall),
      .fetch_en (fetch_en)
   );

   assign dec_stall  = stall;
   assign bubble_ins = stall;
   assign byp_src1   = byp[0];
   assign byp_src2   = byp[1];

   // R1: the first cycle out of reset carries no stall and no bypass
   p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!dec_stall && !byp_src1 && !byp_src2 && fetch_en));
   // R7: a shared port is never granted to fetch beside a data access
   p_shared_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!split_mem && st_v[STG_MEM] && st_mop[STG_MEM]) |-> !fetch_en);
endmodule

// File: tb/pipe_issue_ctl_tb.sv
module pipe_issue_ctl_tb;
   localparam int RW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic split_mem = 1'b0, dec_valid = 1'b0;
   logic dec_src1_use = 1'b0, dec_src2_use = 1'b0;
   logic [RW-1:0] dec_src1 = '0, dec_src2 = '0, dec_dst = '0;
   logic dec_wr = 1'b0, dec_load = 1'b0, dec_store = 1'b0;
   logic fetch_en, dec_stall, bubble_ins, byp_src1, byp_src2;
   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   pipe_issue_ctl #(.REG_W(RW)) u_dut (
      .clk(clk), .rst_n(rst_n), .split_mem(split_mem), .dec_valid(dec_valid),
      .dec_src1_use(dec_src1_use), .dec_src1(dec_src1),
      .dec_src2_use(dec_src2_use), .dec_src2(dec_src2),
      .dec_dst(dec_dst), .dec_wr(dec_wr), .dec_load(dec_load), .dec_store(dec_store),
      .fetch_en(fetch_en), .dec_stall(dec_stall), .bubble_ins(bubble_ins),
      .byp_src1(byp_src1), .byp_src2(byp_src2)
   );

   typedef struct packed {
      logic split, v, u1;
      logic [4:0] s1;
      logic u2;
      logic [4:0] s2;
      logic [4:0] rd;
      logic wr, ld, st;
      logic ef, es, b1, b2;
   } vec_t;

   // split v u1 s1 u2 s2 rd wr ld st | fetch stall byp1 byp2
   localparam int NV = 14;
   localparam vec_t TBL [NV] = '{
      '{1'b0,1'b1,1'b1,5'd2,1'b0,5'd0,5'd1,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0}, // load r1
      '{1'b0,1'b1,1'b1,5'd1,1'b1,5'd1,5'd3,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0}, // R2 load in EX
      '{1'b0,1'b1,1'b1,5'd1,1'b1,5'd1,5'd3,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0}, // R3 load in MEM
      '{1'b0,1'b1,1'b1,5'd1,1'b1,5'd1,5'd3,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1}, // R4 R6 release
      '{1'b0,1'b1,1'b1,5'd0,1'b1,5'd4,5'd0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0}, // R5 store base r0
      '{1'b0,1'b1,1'b0,5'd3,1'b1,5'd5,5'd6,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0}, // R10 unused src
      '{1'b0,1'b1,1'b1,5'd3,1'b1,5'd6,5'd7,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b0}, // R2 R6 byp1 only
      '{1'b0,1'b1,1'b1,5'd3,1'b1,5'd6,5'd7,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0}, // R3 R5 wb no write
      '{1'b0,1'b1,1'b1,5'd3,1'b1,5'd6,5'd7,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b1}, // R6 byp2 only
      '{1'b0,1'b0,1'b0,5'd0,1'b0,5'd0,5'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0}, // idle
      '{1'b0,1'b0,1'b0,5'd0,1'b0,5'd0,5'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0}, // idle
      '{1'b0,1'b1,1'b0,5'd0,1'b0,5'd0,5'd9,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0}, // rd9 no write
      '{1'b0,1'b1,1'b1,5'd9,1'b0,5'd0,5'd2,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0}, // R5 no stall
      '{1'b0,1'b0,1'b0,5'd0,1'b0,5'd0,5'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0}  // idle
   };

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(input logic sp, input logic v, input logic u1, input logic [4:0] s1,
                        input logic u2, input logic [4:0] s2, input logic [4:0] rd,
                        input logic wr, input logic ld, input logic st);
      split_mem = sp; dec_valid = v; dec_src1_use = u1; dec_src1 = s1;
      dec_src2_use = u2; dec_src2 = s2; dec_dst = rd; dec_wr = wr;
      dec_load = ld; dec_store = st;
   endtask

   task automatic expect_all(input string req, input logic ef, input logic es,
                             input logic b1, input logic b2);
      #1;
      chk({req, " fetch_en"}, fetch_en, ef);
      chk({req, " dec_stall"}, dec_stall, es);
      chk({req, " bubble_ins"}, bubble_ins, es);
      chk({req, " byp_src1"}, byp_src1, b1);
      chk({req, " byp_src2"}, byp_src2, b2);
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
      $finish;
   end

   initial begin
      // R1: reset state, even with a dependent-looking decode
      drive(0, 1, 1, 5'd1, 1, 5'd1, 5'd1, 1, 1, 0);
      repeat (2) @(negedge clk);
      expect_all("R1 in reset", 1, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      rst_n = 1'b1;

      // table walk: R2 R3 R4 R5 R6 R10
      for (int i = 0; i < NV; i++) begin
         drive(TBL[i].split, TBL[i].v, TBL[i].u1, TBL[i].s1, TBL[i].u2, TBL[i].s2,
               TBL[i].rd, TBL[i].wr, TBL[i].ld, TBL[i].st);
         expect_all($sformatf("table row %0d (R2 R3 R4 R5 R6 R10)", i),
                    TBL[i].ef, TBL[i].es, TBL[i].b1, TBL[i].b2);
      end

      // R8 and R7: data access in memory stage under both modes
      drive(1, 1, 0, 0, 0, 0, 5'd1, 1, 1, 0);
      expect_all("R8 load issue", 1, 0, 0, 0);
      drive(1, 1, 1, 5'd0, 0, 0, 5'd0, 0, 0, 1);
      expect_all("R8 store issue", 1, 0, 0, 0);
      drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      expect_all("R8 load in memory stage", 1, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      expect_all("R7 store in memory stage shared", 0, 0, 0, 0);
      expect_all("R7 port free again", 1, 0, 0, 0);

      // R9: store held behind a load; bubbles must not touch the port
      drive(0, 1, 0, 0, 0, 0, 5'd1, 1, 1, 0);
      expect_all("R9 load issue", 1, 0, 0, 0);
      drive(0, 1, 1, 5'd0, 1, 5'd1, 5'd0, 0, 0, 1);
      expect_all("R9 R2 store held, load in EX", 0, 1, 0, 0);
      expect_all("R9 R3 store held, load in MEM", 0, 1, 0, 0);
      expect_all("R9 R4 store released", 1, 0, 0, 1);
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      expect_all("R9 bubble in memory stage", 1, 0, 0, 0);
      expect_all("R9 R7 store in memory stage", 0, 0, 0, 0);
      expect_all("R9 after store", 1, 0, 0, 0);

      // R1: reset while a producer is in flight clears the record
      drive(0, 1, 0, 0, 0, 0, 5'd4, 1, 1, 0);
      @(negedge clk);
      drive(0, 1, 1, 5'd4, 1, 5'd4, 5'd5, 1, 0, 0);
      #1;
      chk("R2 pre-reset stall", dec_stall, 1'b1);
      rst_n = 1'b0;
      #1;
      chk("R1 reset clears stall", dec_stall, 1'b0);
      chk("R1 reset fetch", fetch_en, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      expect_all("R1 first cycle after reset", 1, 0, 0, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule